// File: doc/BRIEF.md
# SDRAM Access Controller

This block sits between a simple host request port and one x8 SDRAM device with four banks, 8192 rows and 1024 columns. The host presents a read or write with a 25-bit word address, a data byte and a write-mask bit under a valid/ready handshake. The controller turns each request into a row activation followed by a single column access that closes the row by itself, so every access is a closed-page access. Read data comes back as a one-cycle response pulse once the programmed CAS latency has elapsed.

After reset the controller runs the power-up sequence on its own: a long stretch of no-operation commands, a precharge of all banks, two refresh cycles, and a mode-register load that selects a burst of one, sequential order and the CAS latency. No host request is taken until that sequence is over. From then on a free-running interval timer raises refresh requests, and a pending refresh wins over a waiting host request as soon as the current access has finished.

Every gap between commands is a parameter counted in clock cycles, with no-operation commands filling the gaps. The data pins are modelled as a separate input bus, output bus and output enable.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is high the pins show clock-enable low, a no-operation command (chip-select, row strobe, column strobe and write strobe = 0,1,1,1), mask high and output enable low, and `req_ready` and `rsp_valid` are low.
- R2: After reset at least INIT_CYCLES cycles of no-operation pass, then PRECHARGE with A10 high, AUTO REFRESH exactly TRP cycles later, a second AUTO REFRESH exactly TRC cycles after that, and LOAD MODE exactly TRC cycles after that with bank 0 and A = CL in A[6:4] and zeros elsewhere. `req_ready` stays low until after LOAD MODE.
- R3: Commands on {cs_n, ras_n, cas_n, we_n} are: no-op 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, load mode 0000.
- R4: Host address bits [24:23] give the bank, [22:10] the row and [9:0] the column. Activate carries bank and row. The column command carries the same bank, the column on A[9:0], A10 high (close the row after the access) and A[12:11] low.
- R5: The column command comes exactly TRCD cycles after its activate. Between two row commands (activate or refresh) there are at least TRC cycles, at least TWR+TRP cycles after a write, and at least CL+TRP cycles after a read.
- R6: The output enable is high only in the write command cycle, where the output bus holds the host byte. The mask pin in that cycle equals the host mask bit, so a masked write leaves the stored byte unchanged.
- R7: The mask pin is low during a read command. `rsp_valid` pulses for exactly one cycle, CL+1 edges after the edge that samples the read command, and `rsp_rdata` holds the input bus as sampled CL edges after that edge.
- R8: Once initialisation is done, a refresh request is raised every REFI cycles, so refresh commands in idle time are exactly REFI cycles apart. A pending refresh drops `req_ready`, and its refresh command goes out before the next activate, TRC cycles ahead of it.
- R9: Clock-enable is high in every cycle after the first clock edge that follows reset.
- R10: A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the access sequence has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Word address: bank, row, column |
| req_wdata | input | 8 | Write byte |
| req_wmask | input | 1 | 1 = write is blocked by the mask pin |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Multiplexed row/column address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 8 | Data toward the device |
| sd_dq_oe | output | 1 | Output enable for the data pins |
| sd_dq_in | input | 8 | Data from the device |

## Verification
A bench model of the device stores bytes by bank, open row and column, and returns them after the CAS latency. The access table mixes writes and reads in the lowest corner and the highest corner of the address space. Two rows that share bank and column separate row from column decoding, and a masked write to a location that already holds data shows whether the mask really blocks the write. A read of a location never written returns a byte derived from its address, which would expose a controller that returns stale data. Idle stretches measure the refresh period, and a request raised while a refresh is pending shows whether refresh takes priority.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int BANK_W  = 2;
    localparam int ROW_W   = 13;
    localparam int COL_W   = 10;
    localparam int DATA_W  = 8;
    localparam int HADDR_W = BANK_W + ROW_W + COL_W;
    localparam int AP_BIT  = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdc_cmd_e;

    typedef enum logic [2:0] {
        ST_WAIT, ST_PALL, ST_IREF1, ST_IREF2, ST_LMR, ST_IDLE, ST_COL
    } sdc_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } sdc_addr_t;

    typedef struct packed {
        logic              we;
        logic              mask;
        sdc_addr_t         addr;
        logic [DATA_W-1:0] wdata;
    } sdc_req_t;

    // burst of one, sequential order, latency in A[6:4]
    function automatic logic [ROW_W-1:0] mode_word(input int cl);
        return ROW_W'((cl & 7) << 4);
    endfunction

    function automatic int gap_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
    parameter int REFI = 1100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(REFI + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (ack) pending <= 1'b0;
            if (run) begin
                if (cnt == CW'(REFI - 1)) begin
                    cnt     <= '0;
                    pending <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R8: a raised request is held until the controller takes it
    p_pending_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (pending && !ack) |=> pending);

endmodule

// File: rtl/sdc_rd_capture.sv
module sdc_rd_capture #(
    parameter int CL     = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [CL-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            pipe      <= {pipe[CL-2:0], rd_issue};
            rsp_valid <= pipe[CL-1];
            if (pipe[CL-1]) rsp_data <= dq_in;
        end
    end

    // R7: a response appears only a fixed latency after a read command
    p_rsp_latency_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_issue, CL + 1));

endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
    import sdc_pkg::*;
#(
    parameter int INIT_CYCLES = 14300,
    parameter int CL          = 3,
    parameter int TRCD        = 3,
    parameter int TRP         = 3,
    parameter int TRC         = 9,
    parameter int TMRD        = 2,
    parameter int TWR         = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  sdc_req_t          req,
    input  logic              ref_pending,
    output logic              ref_ack,
    output logic              init_done,
    output sdc_cmd_e          cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ROW_W-1:0]  a_o,
    output logic              dqm_o,
    output logic [DATA_W-1:0] dq_out_o,
    output logic              dq_oe_o,
    output logic              cke_o
);
    localparam int TWPOST  = gap_max(TWR + TRP, TRC - TRCD);
    localparam int TRPOST  = gap_max(CL + TRP, TRC - TRCD);
    localparam int CNT_MAX = gap_max(INIT_CYCLES, gap_max(TRC, gap_max(TWPOST, TRPOST)));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [ROW_W-1:0] A_AP = ROW_W'(1) << AP_BIT;

    sdc_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    sdc_req_t         req_q;

    assign req_ready = (state == ST_IDLE) && !ref_pending;
    assign ref_ack   = (state == ST_IDLE) && ref_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAIT;
            nxt       <= ST_PALL;
            cnt       <= CNT_W'(INIT_CYCLES);
            req_q     <= '0;
            init_done <= 1'b0;
            cmd_o     <= CMD_NOP;
            ba_o      <= '0;
            a_o       <= '0;
            dqm_o     <= 1'b1;
            dq_out_o  <= '0;
            dq_oe_o   <= 1'b0;
            cke_o     <= 1'b0;
        end else begin
            cke_o   <= 1'b1;
            cmd_o   <= CMD_NOP;
            dq_oe_o <= 1'b0;
            dqm_o   <= !init_done;
            case (state)
                ST_WAIT: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CNT_W'(1)) state <= nxt;
                end
                ST_PALL: begin
                    cmd_o <= CMD_PRE;
                    ba_o  <= '0;
                    a_o   <= A_AP;
                    state <= ST_WAIT;
                    cnt   <= CNT_W'(TRP - 1);
                    nxt   <= ST_IREF1;
                end
                ST_IREF1, ST_IREF2: begin
                    cmd_o <= CMD_REF;
                    state <= ST_WAIT;
                    cnt   <= CNT_W'(TRC - 1);
                    nxt   <= (state == ST_IREF1) ? ST_IREF2 : ST_LMR;
                end
                ST_LMR: begin
                    cmd_o     <= CMD_LMR;
                    ba_o      <= '0;
                    a_o       <= mode_word(CL);
                    init_done <= 1'b1;
                    state     <= ST_WAIT;
                    cnt       <= CNT_W'(TMRD - 1);
                    nxt       <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        cmd_o <= CMD_REF;
                        state <= ST_WAIT;
                        cnt   <= CNT_W'(TRC - 1);
                        nxt   <= ST_IDLE;
                    end else if (req_valid) begin
                        cmd_o <= CMD_ACT;
                        ba_o  <= req.addr.bank;
                        a_o   <= req.addr.row;
                        req_q <= req;
                        state <= ST_WAIT;
                        cnt   <= CNT_W'(TRCD - 1);
                        nxt   <= ST_COL;
                    end
                end
                ST_COL: begin
                    ba_o  <= req_q.addr.bank;
                    a_o   <= A_AP | ROW_W'(req_q.addr.col);
                    state <= ST_WAIT;
                    nxt   <= ST_IDLE;
                    if (req_q.we) begin
                        cmd_o    <= CMD_WR;
                        dq_out_o <= req_q.wdata;
                        dq_oe_o  <= 1'b1;
                        dqm_o    <= req_q.mask;
                        cnt      <= CNT_W'(TWPOST - 1);
                    end else begin
                        cmd_o <= CMD_RD;
                        dqm_o <= 1'b0;
                        cnt   <= CNT_W'(TRPOST - 1);
                    end
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    // cycles since the last activate and since the last row command
    logic [7:0] since_act, since_row;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 8'hFF;
            since_row <= 8'hFF;
        end else begin
            since_act <= (cmd_o == CMD_ACT) ? 8'd1 :
                         (since_act == 8'hFF) ? since_act : since_act + 8'd1;
            since_row <= (cmd_o == CMD_ACT || cmd_o == CMD_REF) ? 8'd1 :
                         (since_row == 8'hFF) ? since_row : since_row + 8'd1;
        end
    end

    // R5: column command lands exactly TRCD after its activate
    p_col_after_act_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> since_act == 8'(TRCD));

    // R5: row commands are spaced by at least TRC
    p_row_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT || cmd_o == CMD_REF) |-> since_row >= 8'(TRC));

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
    import sdc_pkg::*;
#(
    parameter int INIT_CYCLES = 14300,
    parameter int REFI        = 1100,
    parameter int CL          = 3,
    parameter int TRCD        = 3,
    parameter int TRP         = 3,
    parameter int TRC         = 9,
    parameter int TMRD        = 2,
    parameter int TWR         = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [HADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               req_wmask,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               sd_cke,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [BANK_W-1:0]  sd_ba,
    output logic [ROW_W-1:0]   sd_a,
    output logic               sd_dqm,
    output logic [DATA_W-1:0]  sd_dq_out,
    output logic               sd_dq_oe,
    input  logic [DATA_W-1:0]  sd_dq_in
);
    sdc_req_t req;
    sdc_cmd_e cmd;
    logic     ref_pending, ref_ack, init_done;

    assign req = '{we: req_we, mask: req_wmask, addr: sdc_addr_t'(req_addr), wdata: req_wdata};
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    sdc_ctrl #(
        .INIT_CYCLES(INIT_CYCLES), .CL(CL), .TRCD(TRCD), .TRP(TRP),
        .TRC(TRC), .TMRD(TMRD), .TWR(TWR)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req(req),
        .ref_pending(ref_pending), .ref_ack(ref_ack), .init_done(init_done),
        .cmd_o(cmd), .ba_o(sd_ba), .a_o(sd_a), .dqm_o(sd_dqm),
        .dq_out_o(sd_dq_out), .dq_oe_o(sd_dq_oe), .cke_o(sd_cke)
    );

    sdc_refresh_timer #(.REFI(REFI)) u_refresh (
        .clk(clk), .rst(rst), .run(init_done), .ack(ref_ack), .pending(ref_pending)
    );

    sdc_rd_capture #(.CL(CL), .DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst(rst), .rd_issue(cmd == CMD_RD), .dq_in(sd_dq_in),
        .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
    );

    // R6: data pins are driven only while a write command is on the bus
    p_oe_in_write_r6: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (cmd == CMD_WR));

    // R9: clock enable stays high once reset has been released
    p_cke_on_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> sd_cke);

endmodule

// File: tb/sdram_ctrl_tb_top.sv
module sdram_ctrl_tb_top;
    import sdc_pkg::*;

    localparam int INIT_CYCLES = 40;
    localparam int REFI = 400;
    localparam int CL = 3, TRCD = 3, TRP = 3, TRC = 9, TMRD = 2, TWR = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic req_valid = 1'b0, req_we = 1'b0, req_wmask = 1'b0;
    logic [24:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic sd_dqm, sd_dq_oe;
    logic [7:0] rsp_rdata, sd_dq_out, sd_dq_in;
    logic [1:0] sd_ba;
    logic [12:0] sd_a;

    sdram_ctrl #(
        .INIT_CYCLES(INIT_CYCLES), .REFI(REFI), .CL(CL), .TRCD(TRCD),
        .TRP(TRP), .TRC(TRC), .TMRD(TMRD), .TWR(TWR)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wmask(req_wmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [24:0] a);
        return a[7:0] ^ a[17:10] ^ 8'h5A;
    endfunction

    // ---------------- device model and command monitor ----------------
    logic [7:0]  mem [logic [24:0]];
    logic [7:0]  exp_mem [logic [24:0]];
    logic [12:0] open_row [4];
    logic [7:0]  mpipe [CL];
    assign sd_dq_in = mpipe[CL-1];

    int cyc = 0, last_row = -1000, last_act = -1000, last_wr = -1000, last_rd = -1000;
    int last_ref = -1000, prev_ref = -1000, nref = 0, rd_cyc = 0;
    int ev_n = 0;
    logic [3:0]  ev_c [4];
    int          ev_t [4];
    logic [12:0] ev_a [4];
    logic [1:0]  ev_ba [4];
    logic [1:0]  cur_bank;
    logic [12:0] cur_row;
    logic [9:0]  cur_col;
    logic [7:0]  cur_data;
    logic        cur_mask;

    always @(posedge clk) begin
        logic [3:0]  c;
        logic [24:0] k;
        logic [7:0]  rd;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        rd = 8'h00;
        if (rst) begin
            cyc = 0;
        end else begin
            if (ev_n < 4 && c != CMD_NOP) begin
                ev_c[ev_n] = c; ev_t[ev_n] = cyc; ev_a[ev_n] = sd_a; ev_ba[ev_n] = sd_ba;
                ev_n++;
            end
            if (c == CMD_ACT || c == CMD_REF) begin
                chk(cyc - last_row >= TRC, "R5 row-to-row gap", cyc - last_row, TRC);
                chk(cyc - last_wr >= TWR + TRP, "R5 write-to-row gap", cyc - last_wr, TWR + TRP);
                chk(cyc - last_rd >= CL + TRP, "R5 read-to-row gap", cyc - last_rd, CL + TRP);
                last_row = cyc;
            end
            if (c == CMD_ACT) begin
                chk(sd_ba == cur_bank, "R4 activate bank", sd_ba, cur_bank);
                chk(sd_a == cur_row, "R4 activate row", sd_a, cur_row);
                open_row[sd_ba] = sd_a;
                last_act = cyc;
            end
            if (c == CMD_REF) begin
                prev_ref = last_ref; last_ref = cyc; nref++;
            end
            if (c == CMD_RD || c == CMD_WR) begin
                chk(cyc - last_act == TRCD, "R5 activate-to-column", cyc - last_act, TRCD);
                chk(sd_ba == cur_bank, "R4 column bank", sd_ba, cur_bank);
                chk(sd_a[9:0] == cur_col, "R4 column address", sd_a[9:0], cur_col);
                chk(sd_a[12:10] == 3'b001, "R4 auto-close flag", sd_a[12:10], 1);
                k = {sd_ba, open_row[sd_ba], sd_a[9:0]};
                if (c == CMD_WR) begin
                    chk(sd_dq_oe == 1'b1, "R6 oe in write", sd_dq_oe, 1);
                    chk(sd_dq_out == cur_data, "R6 write byte", sd_dq_out, cur_data);
                    chk(sd_dqm == cur_mask, "R6 write mask", sd_dqm, cur_mask);
                    if (!sd_dqm) mem[k] = sd_dq_out;
                    last_wr = cyc;
                end else begin
                    chk(sd_dqm == 1'b0, "R7 mask low on read", sd_dqm, 0);
                    chk(sd_dq_oe == 1'b0, "R6 oe low on read", sd_dq_oe, 0);
                    rd = mem.exists(k) ? mem[k] : dflt(k);
                    last_rd = cyc; rd_cyc = cyc;
                end
            end
            cyc++;
        end
        for (int i = 1; i < CL; i++) mpipe[i] <= mpipe[i-1];
        mpipe[0] <= rd;
    end

    // ---------------- host side ----------------
    task automatic host_op(input logic we, input logic mask, input logic [24:0] addr,
                           input logic [7:0] data, input bit at_edge_now);
        logic [7:0] exp;
        int n;
        cur_bank = addr[24:23]; cur_row = addr[22:10]; cur_col = addr[9:0];
        cur_data = data; cur_mask = mask;
        if (!at_edge_now) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_wmask = mask; req_addr = addr; req_wdata = data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
        if (!we) begin
            n = 0;
            while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
            exp = exp_mem.exists(addr) ? exp_mem[addr] : dflt(addr);
            chk(rsp_valid == 1'b1, "R7 response seen", rsp_valid, 1);
            chk(rsp_rdata == exp, "R7 R4 read data", rsp_rdata, exp);
            chk(cyc == rd_cyc + CL + 1, "R7 read latency", cyc - rd_cyc, CL + 1);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R7 one-cycle pulse", rsp_valid, 0);
        end else if (!mask) begin
            exp_mem[addr] = data;
        end
        repeat (12) @(negedge clk);
    endtask

    // {we, mask, bank, row, col, data}; entry 5 reads back after a masked write (R6)
    localparam logic [34:0] VEC [13] = '{
        {1'b1, 1'b0, 2'd0, 13'd5,    10'd3,    8'hA5},
        {1'b0, 1'b0, 2'd0, 13'd5,    10'd3,    8'h00},
        {1'b1, 1'b0, 2'd3, 13'd8191, 10'd1023, 8'h3C},
        {1'b0, 1'b0, 2'd3, 13'd8191, 10'd1023, 8'h00},
        {1'b1, 1'b1, 2'd3, 13'd8191, 10'd1023, 8'hFF},
        {1'b0, 1'b0, 2'd3, 13'd8191, 10'd1023, 8'h00},
        {1'b0, 1'b0, 2'd2, 13'd100,  10'd0,    8'h00},
        {1'b1, 1'b0, 2'd1, 13'd0,    10'd512,  8'h00},
        {1'b1, 1'b0, 2'd1, 13'd1,    10'd512,  8'h81},
        {1'b0, 1'b0, 2'd1, 13'd0,    10'd512,  8'h00},
        {1'b0, 1'b0, 2'd1, 13'd1,    10'd512,  8'h00},
        {1'b1, 1'b0, 2'd2, 13'd100,  10'd0,    8'h7E},
        {1'b0, 1'b0, 2'd2, 13'd100,  10'd0,    8'h00}
    };

    initial begin
        int n, old_ref;
        cur_bank = '0; cur_row = '0; cur_col = '0; cur_data = '0; cur_mask = 1'b0;
        for (int i = 0; i < CL; i++) mpipe[i] = 8'h00;
        for (int i = 0; i < 4; i++) open_row[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sd_cke == 1'b0, "R1 cke low in reset", sd_cke, 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R1 R3 nop in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, CMD_NOP);
        chk(sd_dqm == 1'b1 && sd_dq_oe == 1'b0, "R1 mask high, oe low", {sd_dqm, sd_dq_oe}, 2);
        chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R1 handshake idle", {req_ready, rsp_valid}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sd_cke == 1'b1, "R9 cke high after reset", sd_cke, 1);

        // R2 / R3: initialisation sequence
        n = 0;
        while (!req_ready && n < INIT_CYCLES + 200) begin
            chk(req_ready == 1'b0, "R2 ready low during init", req_ready, 0);
            @(negedge clk); n++;
        end
        chk(ev_n == 4, "R2 four init commands", ev_n, 4);
        chk(ev_c[0] == CMD_PRE, "R2 R3 precharge first", ev_c[0], CMD_PRE);
        chk(ev_a[0][10] == 1'b1, "R2 precharge all banks", ev_a[0][10], 1);
        chk(ev_t[0] >= INIT_CYCLES, "R2 power-up nop stretch", ev_t[0], INIT_CYCLES);
        chk(ev_c[1] == CMD_REF && ev_t[1] - ev_t[0] == TRP, "R2 R3 first refresh",
            ev_t[1] - ev_t[0], TRP);
        chk(ev_c[2] == CMD_REF && ev_t[2] - ev_t[1] == TRC, "R2 second refresh",
            ev_t[2] - ev_t[1], TRC);
        chk(ev_c[3] == CMD_LMR && ev_t[3] - ev_t[2] == TRC, "R2 R3 load mode",
            ev_t[3] - ev_t[2], TRC);
        chk(ev_a[3] == 13'(CL << 4) && ev_ba[3] == 2'd0, "R2 mode word", ev_a[3], CL << 4);
        chk(cyc > ev_t[3], "R2 ready only after load mode", cyc, ev_t[3] + 1);

        // table of accesses
        for (int i = 0; i < 13; i++) begin
            host_op(VEC[i][34], VEC[i][33], VEC[i][32:8], VEC[i][7:0], 1'b0);
        end

        // R8: idle refresh period
        old_ref = nref;
        n = 0;
        while (nref < old_ref + 2 && n < 3 * REFI) begin @(negedge clk); n++; end
        chk(last_ref - prev_ref == REFI, "R8 refresh period", last_ref - prev_ref, REFI);

        // R8: request raised while a refresh is pending
        old_ref = last_ref;
        while (cyc < old_ref + REFI - 4) @(negedge clk);
        n = 0;
        while (req_ready && n < 10) begin @(negedge clk); n++; end
        chk(req_ready == 1'b0, "R8 ready low while refresh pending", req_ready, 0);
        host_op(1'b1, 1'b0, {2'd1, 13'd77, 10'd9}, 8'h42, 1'b1);
        chk(last_ref > old_ref, "R8 refresh issued", last_ref, old_ref + REFI);
        chk(last_act - last_ref == TRC, "R8 refresh before activate", last_act - last_ref, TRC);
        host_op(1'b0, 1'b0, {2'd1, 13'd77, 10'd9}, 8'h00, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule